// File: doc/BRIEF.md
# Sequential turn-signal lighting controller

This block drives two banks of tail lamps, one on the left and one on the right. Each bank has three lamps by default. A request on one side starts a sweep that lights the lamps outward from the inner lamp, one more lamp per step, and then turns them all off. A request on both sides at once starts a hazard flash instead: every lamp on both sides is lit, then every lamp is dark, and this repeats. The lamp outputs depend only on the registered state, so they are clean Moore outputs that can drive lamp drivers directly.

The machine runs on a fast system clock. It moves one step only on a clock edge where the single-cycle advance strobe is high. A divider outside the block pulses that strobe at a visible rate, for example about four pulses per second from a 100 MHz clock. The reset is asynchronous and makes all lamps dark at once, without waiting for a clock edge. Once a sweep has started it always runs to its end. The request inputs are examined only in the dark state.

Top module: `tsig_ctrl`

## Requirements
- R1: While `rst` is high, both lamp vectors read all zeros, and this takes effect without any clock edge.
- R2: The state, and therefore both lamp vectors, changes only on a rising `clk` edge with `step_en` high. With `step_en` low, the outputs hold whatever the request inputs do.
- R3: From dark, an advance with `req_left` high and `req_right` low produces the left vector 001, then 011, then 111, then 000, one value per advance. Bit 0 is the inner lamp and bit 2 is the outer lamp. The right vector stays 000 throughout.
- R4: The right sweep behaves the same way on `lamp_right`, with the same bit order: 001, 011, 111, 000. The left vector stays 000 throughout.
- R5: A sweep that has started runs to the dark state even if its request is released, or if the other request (or both requests) goes high partway through.
- R6: If the same single request is still held when a sweep returns to dark, the next advance starts that sweep again.
- R7: From dark, an advance with both requests high lights all six lamps (111 on each side). The next advance returns to all dark. This alternation continues for as long as both requests stay high.
- R8: From the all-lit hazard state, the next advance always goes to dark, whatever the inputs. The advance after that acts on the inputs at that time, so releasing one request during a hazard flash leads straight into the other side's sweep.
- R9: In the dark state, an advance with neither request high keeps every lamp dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the state register updates on its rising edge |
| rst | input | 1 | Asynchronous active-high reset to the dark state |
| step_en | input | 1 | Single-cycle advance strobe; the state moves only on an edge where this is high |
| req_left | input | 1 | Left turn request |
| req_right | input | 1 | Right turn request |
| lamp_left | output | LAMP_W (3) | Left lamps; bit 0 is the inner lamp |
| lamp_right | output | LAMP_W (3) | Right lamps; bit 0 is the inner lamp |

## Verification
The lamp vectors come straight from the state register. An advance presented before a rising edge therefore shows up at the outputs just after that edge and stays there until the next enabled edge. The only exception is reset, which clears the outputs with no edge at all. The bench changes the inputs on the falling edge. On each rising edge it steps its reference model, but only if `step_en` was high. It compares the outputs at the next falling edge, half a period after the edge that could have changed them. The asynchronous reset is checked one nanosecond after `rst` rises, in the middle of a low clock phase, so a synchronous implementation would still show the lit lamps at that point.

// File: rtl/tsig_pkg.sv
package tsig_pkg;

    // Operating mode of the lamp sequencer.
    typedef enum logic [1:0] {
        MODE_DARK  = 2'd0,
        MODE_HAZ   = 2'd1,
        MODE_LEFT  = 2'd2,
        MODE_RIGHT = 2'd3
    } tsig_mode_e;

endpackage

// File: rtl/tsig_next.sv
module tsig_next
    import tsig_pkg::*;
#(
    parameter int LAMP_W = 3,
    localparam int CNT_W = (LAMP_W > 1) ? $clog2(LAMP_W) : 1
) (
    input  logic             step_en,
    input  logic             req_left,
    input  logic             req_right,
    input  tsig_mode_e       cur_mode,
    input  logic [CNT_W-1:0] cur_step,
    output tsig_mode_e       nxt_mode,
    output logic [CNT_W-1:0] nxt_step
);

    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(LAMP_W - 1);

    typedef struct packed {
        tsig_mode_e       mode;
        logic [CNT_W-1:0] step;
    } nx_t;

    nx_t nx_d;

    always_comb begin
        // Default: hold the current state.
        nx_d.mode = cur_mode;
        nx_d.step = cur_step;
        if (step_en) begin
            unique case (cur_mode)
                MODE_DARK: begin
                    // The inputs are looked at only here.
                    nx_d.step = '0;
                    if (req_left && req_right) begin
                        nx_d.mode = MODE_HAZ;
                    end else if (req_left) begin
                        nx_d.mode = MODE_LEFT;
                    end else if (req_right) begin
                        nx_d.mode = MODE_RIGHT;
                    end else begin
                        nx_d.mode = MODE_DARK;
                    end
                end
                MODE_HAZ: begin
                    nx_d.mode = MODE_DARK;
                    nx_d.step = '0;
                end
                MODE_LEFT, MODE_RIGHT: begin
                    // A sweep ignores the inputs until it has finished.
                    if (cur_step == LAST_STEP) begin
                        nx_d.mode = MODE_DARK;
                        nx_d.step = '0;
                    end else begin
                        nx_d.step = cur_step + 1'b1;
                    end
                end
                default: begin
                    nx_d.mode = MODE_DARK;
                    nx_d.step = '0;
                end
            endcase
        end
    end

    assign nxt_mode = nx_d.mode;
    assign nxt_step = nx_d.step;

endmodule

// File: rtl/tsig_lamp_dec.sv
module tsig_lamp_dec
    import tsig_pkg::*;
#(
    parameter int LAMP_W = 3,
    localparam int CNT_W = (LAMP_W > 1) ? $clog2(LAMP_W) : 1
) (
    input  tsig_mode_e       mode,
    input  logic [CNT_W-1:0] step,
    output logic [LAMP_W-1:0] lamp_left,
    output logic [LAMP_W-1:0] lamp_right
);

    logic [LAMP_W-1:0] fill;

    // Lamp i is lit once the sweep has reached step i (inner lamp first).
    for (genvar i = 0; i < LAMP_W; i++) begin : g_lamp
        assign fill[i]       = (step >= CNT_W'(i));
        assign lamp_left[i]  = (mode == MODE_HAZ) || ((mode == MODE_LEFT)  && fill[i]);
        assign lamp_right[i] = (mode == MODE_HAZ) || ((mode == MODE_RIGHT) && fill[i]);
    end

endmodule

// File: rtl/tsig_ctrl.sv
module tsig_ctrl
    import tsig_pkg::*;
#(
    parameter int LAMP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              req_left,
    input  logic              req_right,
    output logic [LAMP_W-1:0] lamp_left,
    output logic [LAMP_W-1:0] lamp_right
);

    localparam int CNT_W = (LAMP_W > 1) ? $clog2(LAMP_W) : 1;
    localparam logic [CNT_W-1:0]  LAST_STEP = CNT_W'(LAMP_W - 1);
    localparam logic [LAMP_W-1:0] ALL_ON    = '1;

    typedef struct packed {
        tsig_mode_e       mode;
        logic [CNT_W-1:0] step;
    } st_t;

    st_t        st_d, st_q;
    tsig_mode_e nxt_mode;
    logic [CNT_W-1:0] nxt_step;

    tsig_next #(.LAMP_W(LAMP_W)) u_next (
        .step_en   (step_en),
        .req_left  (req_left),
        .req_right (req_right),
        .cur_mode  (st_q.mode),
        .cur_step  (st_q.step),
        .nxt_mode  (nxt_mode),
        .nxt_step  (nxt_step)
    );

    always_comb begin
        st_d.mode = nxt_mode;
        st_d.step = nxt_step;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q.mode <= MODE_DARK;
            st_q.step <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    tsig_lamp_dec #(.LAMP_W(LAMP_W)) u_dec (
        .mode       (st_q.mode),
        .step       (st_q.step),
        .lamp_left  (lamp_left),
        .lamp_right (lamp_right)
    );

    // R2: without an advance strobe the state holds.
    a_r2_hold_without_step: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(st_q));

    // R3 and R4: a sweep that has not reached its last step moves one step further.
    a_r3_sweep_advances: assert property (@(posedge clk) disable iff (rst)
        (step_en && (st_q.mode == MODE_LEFT || st_q.mode == MODE_RIGHT) && st_q.step != LAST_STEP)
        |=> (st_q.mode == $past(st_q.mode)) && (st_q.step == $past(st_q.step) + 1'b1));

    // R5: the last sweep step always ends in dark, whatever the inputs are.
    a_r5_sweep_ends_dark: assert property (@(posedge clk) disable iff (rst)
        (step_en && (st_q.mode == MODE_LEFT || st_q.mode == MODE_RIGHT) && st_q.step == LAST_STEP)
        |=> (lamp_left == '0) && (lamp_right == '0));

    // R7: both requests in dark light every lamp.
    a_r7_hazard_entry: assert property (@(posedge clk) disable iff (rst)
        (step_en && st_q.mode == MODE_DARK && req_left && req_right)
        |=> (lamp_left == ALL_ON) && (lamp_right == ALL_ON));

    // R8: the hazard-on state always steps to dark.
    a_r8_hazard_to_dark: assert property (@(posedge clk) disable iff (rst)
        (step_en && st_q.mode == MODE_HAZ) |=> (st_q.mode == MODE_DARK));

    // R9: dark with no request stays dark.
    a_r9_idle_stays_dark: assert property (@(posedge clk) disable iff (rst)
        (step_en && st_q.mode == MODE_DARK && !req_left && !req_right)
        |=> (lamp_left == '0) && (lamp_right == '0));

    // R3 and R4: the two sides are lit together only while the hazard flash is on.
    a_r4_sides_exclusive: assert property (@(posedge clk) disable iff (rst)
        (lamp_left != '0 && lamp_right != '0)
        |-> (lamp_left == ALL_ON) && (lamp_right == ALL_ON));

endmodule

// File: tb/tsig_ctrl_bench.sv
module tsig_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       step_en;
    logic       req_left;
    logic       req_right;
    logic [2:0] lamp_left;
    logic [2:0] lamp_right;

    int  n_chk  = 0;
    int  n_fail = 0;
    int  ph     = 0;   // reference phase: 0 dark, 1 hazard on, 2..4 left steps, 5..7 right steps
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tsig_ctrl u_tsig_ctrl (
        .clk        (clk),
        .rst        (rst),
        .step_en    (step_en),
        .req_left   (req_left),
        .req_right  (req_right),
        .lamp_left  (lamp_left),
        .lamp_right (lamp_right)
    );

    function automatic int next_ph(int p, bit l, bit r);
        case (p)
            0:       return (l && r) ? 1 : (l ? 2 : (r ? 5 : 0));
            2:       return 3;
            3:       return 4;
            5:       return 6;
            6:       return 7;
            default: return 0;
        endcase
    endfunction

    function automatic logic [5:0] exp_lamps(int p);
        case (p)
            1:       return 6'b111_111;
            2:       return 6'b001_000;
            3:       return 6'b011_000;
            4:       return 6'b111_000;
            5:       return 6'b000_001;
            6:       return 6'b000_011;
            7:       return 6'b000_111;
            default: return 6'b000_000;
        endcase
    endfunction

    task automatic check(string tag);
        logic [5:0] e;
        e = exp_lamps(ph);
        n_chk++;
        if ({lamp_left, lamp_right} !== e) begin
            n_fail++;
            $display("FAIL %s: lamps L=%b R=%b, expected L=%b R=%b",
                     tag, lamp_left, lamp_right, e[5:3], e[2:0]);
        end
    endtask

    // Drive inputs at the falling edge, step the model at the rising edge,
    // compare at the following falling edge.
    task automatic step(bit l, bit r, bit en, string tag);
        req_left  = l;
        req_right = r;
        step_en   = en;
        @(posedge clk);
        if (en) ph = next_ph(ph, l, r);
        @(negedge clk);
        check(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        rst = 1'b1; step_en = 1'b0; req_left = 1'b0; req_right = 1'b0;
        seed = $urandom(32'h5EED_0C7A);
        repeat (2) @(negedge clk);
        check("R1");
        rst = 1'b0;
        @(negedge clk);

        // R9: idle stays dark
        for (int i = 0; i < 3; i++) step(0, 0, 1, "R9");

        // R3 start, then R5 released mid-sweep
        step(1, 0, 1, "R3");
        step(0, 0, 1, "R5");
        step(0, 0, 1, "R5");
        step(0, 0, 1, "R3");

        // R6: held left repeats
        for (int i = 0; i < 4; i++) step(1, 0, 1, "R6");
        step(1, 0, 1, "R6");
        for (int i = 0; i < 3; i++) step(0, 0, 1, "R3");

        // R4 right sweep, with R5 both requests raised mid-sweep
        step(0, 1, 1, "R4");
        step(1, 1, 1, "R5");
        step(1, 0, 1, "R5");
        step(0, 0, 1, "R4");

        // R2: no advance, inputs wiggling
        step(0, 1, 1, "R4");
        step(1, 0, 0, "R2");
        step(1, 1, 0, "R2");
        step(0, 0, 0, "R2");
        step(0, 0, 1, "R2");
        step(0, 0, 1, "R4");
        step(0, 0, 1, "R4");

        // R7: hazard alternation
        for (int i = 0; i < 6; i++) step(1, 1, 1, "R7");

        // R8: release right while on -> dark, then left sweep
        step(1, 1, 1, "R7");
        step(1, 0, 1, "R8");
        step(1, 0, 1, "R8");
        step(0, 0, 1, "R8");

        // R1: asynchronous reset in the middle of a sweep, between edges
        rst = 1'b1;
        #1;
        ph = 0;
        check("R1");
        @(negedge clk);
        check("R1");
        rst = 1'b0;
        @(negedge clk);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            bit l, r, en;
            l  = ($urandom % 3) != 0;
            r  = ($urandom % 3) == 0;
            en = ($urandom % 4) != 0;
            step(l, r, en, "RND");
        end

        finish_run();
    end

endmodule